// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out vector configuration requests of the set-length-from-immediate kind. It holds the current vector type state and the vector length in registers. For each request it works out the largest legal vector length from a fixed vector register width, the requested element width and the requested register grouping. It then decides the new vector length and the value returned to the destination register.

A decoder in front of the unit supplies four things with a valid strobe: two flags saying whether the destination and source register fields are zero, the application vector length taken from the source register, and the type immediate. One clock later the unit presents the updated state on a control-register read port, together with a write-back strobe, a write enable and the write-back data. The form with both register fields zero reuses the present vector length. It is refused, by raising the illegal flag, when the new type would change the maximum length or when the state was already illegal.

Top module: `vcfg_unit`

## Requirements
- R1: During and after a synchronous active-high reset the illegal flag is 1, all other type fields are 0, the vector length is 0, and the write-back strobe is low.
- R2: The type word holds the grouping code in bits [2:0], the width code in bits [5:3], tail-agnostic in bit 6, mask-agnostic in bit 7, and the illegal flag in bit XLEN-1; every other bit reads 0. Width codes 0..3 mean 8, 16, 32 and 64 bits. Grouping codes 0..3 mean 1, 2, 4 and 8. Codes 5, 6 and 7 mean 1/8, 1/4 and 1/2.
- R3: With a nonzero source field, the new vector length is the smaller of the supplied length and the maximum. A nonzero destination receives that length.
- R4: With a zero source field and a nonzero destination, the vector length becomes the maximum and the destination receives the maximum.
- R5: With both fields zero and a new type whose maximum equals the current maximum, the vector length is kept, the type fields are updated, the illegal flag stays 0, and no destination write occurs.
- R6: With both fields zero and a new type whose maximum is larger or smaller than the current one, the illegal flag is set.
- R7: With both fields zero while the illegal flag is already 1, the flag stays 1 whatever the new type is.
- R8: Each of the following sets the illegal flag: a width code above 3, grouping code 4, a nonzero immediate bit above bit 7, or a fractional grouping whose width exceeds ELEN times the grouping.
- R9: Whenever the illegal flag is set, the other type fields and the vector length are 0, and a destination write (if any) carries 0.
- R10: Results appear on the clock edge that samples the valid strobe, and the write-back strobe is high for exactly that one cycle. Without valid, the state does not change.
- R11: The maximum length equals VLEN times the grouping, divided by the element width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| req_rd_zero_i | input | 1 | Destination register field is zero |
| req_rs1_zero_i | input | 1 | Source register field is zero |
| req_avl_i | input | XLEN | Requested application vector length |
| req_vtypei_i | input | VTYPEI_W | Type immediate |
| wb_valid_o | output | 1 | Result strobe, one cycle after the request |
| wb_rd_we_o | output | 1 | Destination register write enable |
| wb_rd_data_o | output | XLEN | Value for the destination register |
| csr_vtype_o | output | XLEN | Current type word |
| csr_vl_o | output | XLEN | Current vector length |

## Verification
The bench builds the unit with XLEN=64, VLEN=256, ELEN=64 and an 11-bit immediate. These values make the maximum length range from 4 up to 256, so the vector length needs its full 9-bit register. Supplied lengths just below, at and above each maximum, including one with only bit 63 set, test whether the clamp compares all 64 bits. The fractional-width limit is reachable at both edges: 8-bit elements at one-eighth grouping are legal, while 64-bit elements at half grouping are refused.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    // Low eight bits of the type immediate / type word, LSB last.
    typedef struct packed {
        logic       ma;
        logic       ta;
        logic [2:0] vsew;
        logic [2:0] vlmul;
    } vtype_fields_t;

    typedef enum logic [1:0] {
        AVL_FROM_REG = 2'd0,
        AVL_FROM_MAX = 2'd1,
        AVL_KEEP     = 2'd2
    } avl_mode_e;

    localparam int unsigned FIELD_BITS  = 8;
    localparam logic [2:0]  VSEW_TOP    = 3'd3;
    localparam logic [2:0]  VLMUL_RSVD  = 3'd4;

    function automatic int sew_log2(input logic [2:0] vsew);
        return 3 + int'(vsew);
    endfunction

    function automatic int lmul_log2(input logic [2:0] vlmul);
        case (vlmul)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 2;
            3'd3:    return 3;
            3'd5:    return -3;
            3'd6:    return -2;
            3'd7:    return -1;
            default: return 0;
        endcase
    endfunction

    function automatic avl_mode_e pick_mode(input logic rd_zero, input logic rs1_zero);
        if (!rs1_zero)    return AVL_FROM_REG;
        else if (!rd_zero) return AVL_FROM_MAX;
        else              return AVL_KEEP;
    endfunction

endpackage

// File: rtl/vcfg_vtype_dec.sv
module vcfg_vtype_dec
    import vcfg_pkg::*;
#(
    parameter int VTYPEI_W = 11,
    parameter int VLEN     = 128,
    parameter int ELEN     = 64,
    parameter int VL_W     = $clog2(VLEN) + 1
) (
    input  logic [VTYPEI_W-1:0] vtypei_i,
    output logic                legal_o,
    output logic [VL_W-1:0]     vlmax_o
);
    localparam int VLEN_LOG2 = $clog2(VLEN);
    localparam int ELEN_LOG2 = $clog2(ELEN);

    logic          rsvd_ok;
    vtype_fields_t f;
    int            lmul_l;
    int            sew_l;
    int            shamt;

    if (VTYPEI_W > FIELD_BITS) begin : g_rsvd
        assign rsvd_ok = (vtypei_i[VTYPEI_W-1:FIELD_BITS] == '0);
    end else begin : g_no_rsvd
        assign rsvd_ok = 1'b1;
    end

    always_comb begin
        f       = vtype_fields_t'(vtypei_i[FIELD_BITS-1:0]);
        lmul_l  = lmul_log2(f.vlmul);
        sew_l   = sew_log2(f.vsew);
        legal_o = rsvd_ok
                  && (f.vsew <= VSEW_TOP)
                  && (f.vlmul != VLMUL_RSVD)
                  && ((ELEN_LOG2 + lmul_l) >= sew_l);
        shamt   = VLEN_LOG2 + lmul_l - sew_l;
        vlmax_o = legal_o ? (VL_W'(1) << shamt) : '0;
    end

endmodule

// File: rtl/vcfg_vl_sel.sv
module vcfg_vl_sel
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VL_W = 8
) (
    input  avl_mode_e        mode_i,
    input  logic             new_legal_i,
    input  logic [VL_W-1:0]  new_vlmax_i,
    input  logic             cur_ok_i,
    input  logic [VL_W-1:0]  cur_vlmax_i,
    input  logic [VL_W-1:0]  cur_vl_i,
    input  logic [XLEN-1:0]  avl_i,
    output logic             next_vill_o,
    output logic [VL_W-1:0]  next_vl_o
);
    always_comb begin
        next_vill_o = !new_legal_i;
        next_vl_o   = new_vlmax_i;
        case (mode_i)
            AVL_FROM_REG: begin
                next_vl_o = (avl_i > XLEN'(new_vlmax_i)) ? new_vlmax_i : avl_i[VL_W-1:0];
            end
            AVL_FROM_MAX: begin
                next_vl_o = new_vlmax_i;
            end
            AVL_KEEP: begin
                next_vill_o = !new_legal_i || !cur_ok_i || (new_vlmax_i != cur_vlmax_i);
                next_vl_o   = cur_vl_i;
            end
            default: begin
                next_vill_o = 1'b1;
            end
        endcase
        if (next_vill_o) begin
            next_vl_o = '0;
        end
    end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int VLEN     = 128,
    parameter int ELEN     = 64,
    parameter int VTYPEI_W = 11
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                req_valid_i,
    input  logic                req_rd_zero_i,
    input  logic                req_rs1_zero_i,
    input  logic [XLEN-1:0]     req_avl_i,
    input  logic [VTYPEI_W-1:0] req_vtypei_i,
    output logic                wb_valid_o,
    output logic                wb_rd_we_o,
    output logic [XLEN-1:0]     wb_rd_data_o,
    output logic [XLEN-1:0]     csr_vtype_o,
    output logic [XLEN-1:0]     csr_vl_o
);
    localparam int VL_W   = $clog2(VLEN) + 1;
    localparam int GAP_W  = XLEN - 1 - FIELD_BITS;

    logic          vill_q;
    vtype_fields_t fields_q;
    logic [VL_W-1:0] vl_q;
    logic          wb_valid_q;
    logic          wb_we_q;
    logic [XLEN-1:0] wb_data_q;

    logic          new_legal;
    logic [VL_W-1:0] new_vlmax;
    logic          cur_legal;
    logic [VL_W-1:0] cur_vlmax;
    logic          next_vill;
    logic [VL_W-1:0] next_vl;
    avl_mode_e     mode;
    vtype_fields_t new_fields;

    assign mode       = pick_mode(req_rd_zero_i, req_rs1_zero_i);
    assign new_fields = vtype_fields_t'(req_vtypei_i[FIELD_BITS-1:0]);

    vcfg_vtype_dec #(
        .VTYPEI_W (VTYPEI_W),
        .VLEN     (VLEN),
        .ELEN     (ELEN),
        .VL_W     (VL_W)
    ) u_dec_new (
        .vtypei_i (req_vtypei_i),
        .legal_o  (new_legal),
        .vlmax_o  (new_vlmax)
    );

    vcfg_vtype_dec #(
        .VTYPEI_W (VTYPEI_W),
        .VLEN     (VLEN),
        .ELEN     (ELEN),
        .VL_W     (VL_W)
    ) u_dec_cur (
        .vtypei_i (VTYPEI_W'(fields_q)),
        .legal_o  (cur_legal),
        .vlmax_o  (cur_vlmax)
    );

    vcfg_vl_sel #(
        .XLEN (XLEN),
        .VL_W (VL_W)
    ) u_vl_sel (
        .mode_i      (mode),
        .new_legal_i (new_legal),
        .new_vlmax_i (new_vlmax),
        .cur_ok_i    (!vill_q && cur_legal),
        .cur_vlmax_i (cur_vlmax),
        .cur_vl_i    (vl_q),
        .avl_i       (req_avl_i),
        .next_vill_o (next_vill),
        .next_vl_o   (next_vl)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            vill_q     <= 1'b1;
            fields_q   <= '0;
            vl_q       <= '0;
            wb_valid_q <= 1'b0;
            wb_we_q    <= 1'b0;
            wb_data_q  <= '0;
        end else begin
            wb_valid_q <= req_valid_i;
            wb_we_q    <= req_valid_i && !req_rd_zero_i;
            if (req_valid_i) begin
                vill_q    <= next_vill;
                fields_q  <= next_vill ? '0 : new_fields;
                vl_q      <= next_vl;
                wb_data_q <= XLEN'(next_vl);
            end
        end
    end

    assign csr_vtype_o  = {vill_q, {GAP_W{1'b0}}, fields_q};
    assign csr_vl_o     = XLEN'(vl_q);
    assign wb_valid_o   = wb_valid_q;
    assign wb_rd_we_o   = wb_we_q;
    assign wb_rd_data_o = wb_data_q;

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
    parameter int XLEN     = 64,
    parameter int VLEN     = 128,
    parameter int VTYPEI_W = 11
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                req_valid_i,
    input logic                req_rd_zero_i,
    input logic                req_rs1_zero_i,
    input logic [VTYPEI_W-1:0] req_vtypei_i,
    input logic                wb_valid_o,
    input logic                wb_rd_we_o,
    input logic [XLEN-1:0]     wb_rd_data_o,
    input logic [XLEN-1:0]     csr_vtype_o,
    input logic [XLEN-1:0]     csr_vl_o
);
    logic keep_form;
    assign keep_form = req_valid_i && req_rd_zero_i && req_rs1_zero_i;

    p_reset_vill_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (csr_vtype_o[XLEN-1] && csr_vl_o == '0 && !wb_valid_o));

    p_vill_clears_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        csr_vtype_o[XLEN-1] |-> (csr_vtype_o[XLEN-2:0] == '0 && csr_vl_o == '0));

    p_vl_bound_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        csr_vl_o <= XLEN'(VLEN));

    p_keep_no_write_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        keep_form |=> (wb_valid_o && !wb_rd_we_o));

    p_vill_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (keep_form && csr_vtype_o[XLEN-1]) |=> csr_vtype_o[XLEN-1]);

    p_idle_stable_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(req_valid_i)) |->
            ($stable(csr_vtype_o) && $stable(csr_vl_o) && !wb_valid_o));

    p_rd_is_vl_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_rd_we_o |-> (wb_rd_data_o == csr_vl_o));

endmodule

bind vcfg_unit vcfg_unit_chk #(
    .XLEN     (XLEN),
    .VLEN     (VLEN),
    .VTYPEI_W (VTYPEI_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .req_valid_i    (req_valid_i),
    .req_rd_zero_i  (req_rd_zero_i),
    .req_rs1_zero_i (req_rs1_zero_i),
    .req_vtypei_i   (req_vtypei_i),
    .wb_valid_o     (wb_valid_o),
    .wb_rd_we_o     (wb_rd_we_o),
    .wb_rd_data_o   (wb_rd_data_o),
    .csr_vtype_o    (csr_vtype_o),
    .csr_vl_o       (csr_vl_o)
);

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;
    localparam int XLEN = 64;
    localparam int VLEN = 256;
    localparam int ELEN = 64;
    localparam int VW   = 11;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_rd_zero = 1'b0;
    logic            req_rs1_zero = 1'b0;
    logic [XLEN-1:0] req_avl = '0;
    logic [VW-1:0]   req_vtypei = '0;
    logic            wb_valid;
    logic            wb_rd_we;
    logic [XLEN-1:0] wb_rd_data;
    logic [XLEN-1:0] csr_vtype;
    logic [XLEN-1:0] csr_vl;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    bit              m_vill = 1'b1;
    logic [7:0]      m_fields = '0;
    longint unsigned m_vl = 0;

    always #2 clk = ~clk;

    vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .VTYPEI_W(VW)) u_vcfg_unit (
        .clk_i          (clk),
        .rst_i          (rst),
        .req_valid_i    (req_valid),
        .req_rd_zero_i  (req_rd_zero),
        .req_rs1_zero_i (req_rs1_zero),
        .req_avl_i      (req_avl),
        .req_vtypei_i   (req_vtypei),
        .wb_valid_o     (wb_valid),
        .wb_rd_we_o     (wb_rd_we),
        .wb_rd_data_o   (wb_rd_data),
        .csr_vtype_o    (csr_vtype),
        .csr_vl_o       (csr_vl)
    );

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] mk(input bit ma, input bit ta, input int sew_code,
                                         input int lmul_code);
        return {3'b000, ma, ta, 3'(sew_code), 3'(lmul_code)};
    endfunction

    // R11/R2/R8 reference: legality and maximum length by plain arithmetic
    function automatic bit ref_legal(input logic [VW-1:0] vti);
        int sewb, num, den;
        if (vti[10:8] != 3'b000 || vti[5:3] > 3 || vti[2:0] == 3'd4) return 1'b0;
        sewb = 8 << vti[5:3];
        num = 1; den = 1;
        case (vti[2:0])
            3'd1: num = 2;
            3'd2: num = 4;
            3'd3: num = 8;
            3'd5: den = 8;
            3'd6: den = 4;
            3'd7: den = 2;
            default: ;
        endcase
        return (sewb * den) <= (ELEN * num);
    endfunction

    function automatic longint unsigned ref_vlmax(input logic [VW-1:0] vti);
        int sewb, num, den;
        sewb = 8 << vti[5:3];
        num = 1; den = 1;
        case (vti[2:0])
            3'd1: num = 2;
            3'd2: num = 4;
            3'd3: num = 8;
            3'd5: den = 8;
            3'd6: den = 4;
            3'd7: den = 2;
            default: ;
        endcase
        return longint'(VLEN * num / (den * sewb));
    endfunction

    task automatic issue(input bit rdz, input bit rs1z, input longint unsigned avl,
                         input logic [VW-1:0] vti, input string tag);
        bit              nl, ill;
        longint unsigned nmax, cmax, nvl;
        logic [XLEN-1:0] exp_vtype;
        nl   = ref_legal(vti);
        nmax = nl ? ref_vlmax(vti) : 0;
        cmax = m_vill ? 0 : ref_vlmax({3'b000, m_fields});
        ill  = !nl;
        if (!rs1z)      nvl = (avl > nmax) ? nmax : avl;
        else if (!rdz)  nvl = nmax;
        else begin
            nvl = m_vl;
            if (m_vill || nmax != cmax) ill = 1'b1;
        end
        if (ill) nvl = 0;
        m_vill   = ill;
        m_fields = ill ? 8'h00 : vti[7:0];
        m_vl     = nvl;
        exp_vtype = {m_vill, 55'b0, m_fields};

        @(negedge clk);
        req_valid = 1'b1; req_rd_zero = rdz; req_rs1_zero = rs1z;
        req_avl = avl; req_vtypei = vti;
        @(negedge clk);
        req_valid = 1'b0;
        check(csr_vtype == exp_vtype, {tag, " type word"}, csr_vtype, exp_vtype);
        check(csr_vl == m_vl, {tag, " vector length"}, csr_vl, m_vl);
        check(wb_valid == 1'b1, {tag, " R10 strobe"}, wb_valid, 1);
        check(wb_rd_we == !rdz, {tag, " write enable"}, wb_rd_we, !rdz);
        if (!rdz) check(wb_rd_data == m_vl, {tag, " rd value"}, wb_rd_data, m_vl);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(csr_vtype == 64'h8000_0000_0000_0000, "R1 reset type", csr_vtype,
              64'h8000_0000_0000_0000);
        check(csr_vl == 0, "R1 reset vl", csr_vl, 0);
        check(wb_valid == 0, "R1 reset strobe", wb_valid, 0);
    endtask

    task automatic t_avl_reg();
        issue(0, 0, 5,  mk(1, 0, 2, 0), "R3 e32m1 avl5");
        issue(0, 0, 8,  mk(0, 1, 2, 0), "R3 e32m1 avl=max");
        issue(0, 0, 9,  mk(1, 1, 2, 0), "R3 e32m1 avl>max");
        issue(0, 0, 0,  mk(0, 0, 2, 0), "R3 avl0");
        issue(0, 0, 64'h8000_0000_0000_0000, mk(0, 0, 0, 3), "R3 R11 e8m8 huge avl");
        issue(0, 0, 1000, mk(0, 1, 1, 7), "R3 R11 e16mf2");
        issue(1, 0, 3, mk(0, 0, 3, 1), "R3 rd zero e64m2");
    endtask

    task automatic t_avl_max();
        issue(0, 1, 0, mk(1, 0, 3, 3), "R4 R11 e64m8");
        issue(0, 1, 99, mk(0, 0, 0, 5), "R4 R2 e8mf8");
        issue(0, 1, 0, mk(0, 0, 1, 6), "R4 R2 e16mf4");
    endtask

    task automatic t_keep_same();
        issue(0, 0, 7, mk(0, 0, 2, 1), "R3 setup e32m2");
        issue(1, 1, 0, mk(1, 1, 1, 0), "R5 e16m1 same max");
        issue(1, 1, 0, mk(1, 1, 1, 0), "R5 repeat same");
    endtask

    task automatic t_keep_change();
        issue(1, 1, 0, mk(0, 0, 1, 1), "R6 max grows");
        issue(0, 0, 3, mk(0, 0, 0, 0), "R3 setup e8m1");
        issue(1, 1, 0, mk(0, 0, 0, 7), "R6 max shrinks");
    endtask

    task automatic t_keep_after_vill();
        issue(1, 1, 0, mk(0, 0, 0, 0), "R7 already illegal");
        issue(1, 1, 0, mk(0, 0, 1, 1), "R7 still illegal");
    endtask

    task automatic t_illegal();
        issue(0, 0, 4, mk(0, 0, 0, 0), "R3 setup legal");
        issue(0, 0, 4, mk(0, 0, 4, 0), "R8 R9 bad width");
        issue(0, 0, 4, mk(0, 0, 0, 0), "R3 setup legal");
        issue(0, 1, 4, mk(0, 0, 0, 4), "R8 R9 bad grouping");
        issue(0, 0, 4, mk(0, 0, 0, 0) | 11'h100, "R8 R9 reserved bit");
        issue(0, 1, 0, mk(0, 0, 3, 7), "R8 R9 e64mf2");
        issue(0, 1, 0, mk(0, 0, 0, 5), "R8 e8mf8 legal edge");
    endtask

    task automatic t_idle();
        logic [XLEN-1:0] v0, l0;
        issue(0, 0, 6, mk(1, 0, 1, 2), "R3 setup idle");
        v0 = csr_vtype; l0 = csr_vl;
        req_avl = 64'd1; req_vtypei = mk(0, 0, 3, 7); req_rs1_zero = 1'b1; req_rd_zero = 1'b1;
        repeat (3) @(negedge clk);
        check(csr_vtype == v0, "R10 idle type", csr_vtype, v0);
        check(csr_vl == l0, "R10 idle vl", csr_vl, l0);
        check(wb_valid == 0, "R10 idle strobe", wb_valid, 0);
    endtask

    initial begin
        t_reset();
        t_avl_reg();
        t_avl_max();
        t_keep_same();
        t_keep_change();
        t_keep_after_vill();
        t_illegal();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule